// File: doc/BRIEF.md
# System clock divider controller with staged ratio changes

The block derives a set of system clock edge strobes from one of two sources: the reference input, or a faster multiplied clock supplied from outside. Both sources arrive as single-cycle edge strobes in the controller's own clock domain. A control bit picks the source. Each system output has its own integer divider with an enable. Two further dividers run straight from the reference input and produce a bypass clock and an observation clock.

Software writes new system divide ratios into pending registers. They stay pending until a GO command is written. The GO sequence waits until the slowest of the selected outputs reaches the end of its current period. On that source edge it loads every changed ratio and restarts the selected counters together, so their next edges coincide. A busy status stays high while the sequence runs. A per-divider flag shows which ratios were changed since the last GO. Ratio writes made while a GO runs are held for the next GO.

Top module: `clkdiv_ctrl`

## Requirements
- R1: After reset the system ratio fields read 0, 2 and 5 (divide by 1, 3 and 6), each with its enable bit 15 set. The bypass and observation dividers read 0x8000, source select (bit 0 at address 0) reads 0, align mask (address 5) reads 0b111, busy (bit 0 at address 4) reads 0, change flags (address 6) read 0 and the on-status (address 7) reads 0b111.
- R2: With bit 0 at address 0 set, the system dividers count edges of the multiplied input. With it clear, they count reference edges.
- R3: A ratio field value v (bits 4:0) gives one output pulse every v+1 counted source edges. The pulse appears one clock after the source edge.
- R4: Bit 15 of a system divider register (addresses 8 + i) gates that output at once, and bit i of the on-status register mirrors it.
- R5: A write to a system divider register updates its read-back value but not the running period until a GO. It sets change flag i when the written ratio differs from the pending one.
- R6: Writing 1 to bit 0 of address 3 starts a GO and raises busy. Writing 0 there has no effect.
- R7: A GO completes on the source edge where the aligned divider with the largest active ratio ends its period. It completes on the next source edge if the align mask is empty. On that edge, changed ratios load and aligned counters restart, so all enabled aligned outputs pulse together on the following source edge. Busy clears one clock after the completing edge.
- R8: Starting a GO clears the change flags. Ratio writes made while busy are stored and flagged, and take effect only through the next GO.
- R9: A GO command written while busy is ignored.
- R10: The bypass (address 1) and observation (address 2) dividers always count reference edges. A write takes effect at once, with no GO. Bit 15 enables the output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_edge | input | 1 | One-cycle strobe per reference clock edge |
| mul_edge | input | 1 | One-cycle strobe per multiplied clock edge |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| sys_pulse | output | NUM_SYS | Edge strobes of the system clocks |
| byp_pulse | output | 1 | Edge strobe of the bypass clock |
| obs_pulse | output | 1 | Edge strobe of the observation clock |
| go_busy | output | 1 | GO sequence in progress |

## Verification
The bench builds the block with its defaults of three system outputs and 5-bit ratio fields. Those sizes keep the longest period (divide by 6 on a reference strobe every fourth clock) short enough to measure several times within a run. A multiplied strobe every second clock lets a source switch show up as a halved period. The GO sequence is started just after the slowest output pulses, so writes made during busy and a second GO are certain to fall inside the busy window, and the common restart edge can be checked across all three outputs.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
   localparam int REG_AW = 4;
   localparam int REG_DW = 16;
   localparam int EN_POS = 15;

   localparam logic [REG_AW-1:0] A_CTRL  = 4'd0;
   localparam logic [REG_AW-1:0] A_BYP   = 4'd1;
   localparam logic [REG_AW-1:0] A_OBS   = 4'd2;
   localparam logic [REG_AW-1:0] A_GO    = 4'd3;
   localparam logic [REG_AW-1:0] A_STAT  = 4'd4;
   localparam logic [REG_AW-1:0] A_ALIGN = 4'd5;
   localparam logic [REG_AW-1:0] A_CHG   = 4'd6;
   localparam logic [REG_AW-1:0] A_CLKON = 4'd7;
   localparam logic [REG_AW-1:0] A_SYS0  = 4'd8;

   // reset ratio field (divide minus one) of system divider idx
   function automatic int sys_reset_ratio(input int idx);
      case (idx)
         0:       return 0;
         1:       return 2;
         default: return 5;
      endcase
   endfunction
endpackage

// File: rtl/clkdiv_counter.sv
module clkdiv_counter #(
   parameter int RATIO_W = 5,
   parameter logic [RATIO_W-1:0] RST_RATIO = '0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               step,
   input  logic               en,
   input  logic               load,
   input  logic [RATIO_W-1:0] load_ratio,
   input  logic               restart,
   output logic               pulse,
   output logic               at_end,
   output logic [RATIO_W-1:0] ratio_q
);
   logic [RATIO_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt     <= '0;
         ratio_q <= RST_RATIO;
         pulse   <= 1'b0;
      end else begin
         if (load)
            ratio_q <= load_ratio;
         pulse <= step && en && (cnt == '0);
         if (step) begin
            if (restart || cnt >= ratio_q)
               cnt <= '0;
            else
               cnt <= cnt + 1'b1;
         end
      end
   end

   assign at_end = (cnt == ratio_q);

   AST_RESTART_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (step && restart) |=> (cnt == '0)); // R7
   AST_COUNT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(cnt)); // R3
endmodule

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
   import clkdiv_pkg::*;
#(
   parameter int NUM_SYS = 3,
   parameter int RATIO_W = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [REG_AW-1:0]               wr_addr,
   input  logic [REG_DW-1:0]               wr_data,
   input  logic [REG_AW-1:0]               rd_addr,
   output logic [REG_DW-1:0]               rd_data,
   input  logic                            busy,
   output logic                            go_start,
   output logic                            mul_sel,
   output logic [NUM_SYS-1:0]              sys_en,
   output logic [NUM_SYS-1:0][RATIO_W-1:0] armed,
   output logic [NUM_SYS-1:0]              apply_mask,
   output logic [NUM_SYS-1:0]              align,
   output logic                            byp_en,
   output logic                            byp_load,
   output logic                            obs_en,
   output logic                            obs_load
);
   logic [NUM_SYS-1:0][RATIO_W-1:0] pend;
   logic [NUM_SYS-1:0]              chg;
   logic [RATIO_W-1:0]              byp_r, obs_r;
   logic [RATIO_W-1:0]              wr_ratio;
   logic                            unused_bits;

   assign wr_ratio    = wr_data[RATIO_W-1:0];
   assign unused_bits = ^wr_data[EN_POS-1:RATIO_W];
   assign go_start    = wr_en && (wr_addr == A_GO) && wr_data[0] && !busy;
   assign byp_load    = wr_en && (wr_addr == A_BYP);
   assign obs_load    = wr_en && (wr_addr == A_OBS);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mul_sel <= 1'b0;
         align   <= '1;
         byp_r   <= '0;
         byp_en  <= 1'b1;
         obs_r   <= '0;
         obs_en  <= 1'b1;
      end else if (wr_en) begin
         case (wr_addr)
            A_CTRL:  mul_sel <= wr_data[0];
            A_ALIGN: align   <= wr_data[NUM_SYS-1:0];
            A_BYP:   begin byp_r <= wr_ratio; byp_en <= wr_data[EN_POS]; end
            A_OBS:   begin obs_r <= wr_ratio; obs_en <= wr_data[EN_POS]; end
            default: ;
         endcase
      end
   end

   for (genvar i = 0; i < NUM_SYS; i++) begin : g_sysreg
      localparam logic [RATIO_W-1:0] RST_R = RATIO_W'(sys_reset_ratio(i));
      logic sel;
      assign sel = wr_en && (wr_addr == A_SYS0 + REG_AW'(i));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend[i]       <= RST_R;
            armed[i]      <= RST_R;
            sys_en[i]     <= 1'b1;
            chg[i]        <= 1'b0;
            apply_mask[i] <= 1'b0;
         end else if (sel) begin
            pend[i]   <= wr_ratio;
            sys_en[i] <= wr_data[EN_POS];
            if (wr_ratio != pend[i])
               chg[i] <= 1'b1;
         end else if (go_start) begin
            armed[i]      <= pend[i];
            apply_mask[i] <= chg[i];
            chg[i]        <= 1'b0;
         end
      end

      AST_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
         (sel && wr_ratio != pend[i]) |=> chg[i]); // R5
   end

   always_comb begin
      rd_data = '0;
      case (rd_addr)
         A_CTRL:  rd_data[0] = mul_sel;
         A_BYP:   begin rd_data[RATIO_W-1:0] = byp_r; rd_data[EN_POS] = byp_en; end
         A_OBS:   begin rd_data[RATIO_W-1:0] = obs_r; rd_data[EN_POS] = obs_en; end
         A_STAT:  rd_data[0] = busy;
         A_ALIGN: rd_data[NUM_SYS-1:0] = align;
         A_CHG:   rd_data[NUM_SYS-1:0] = chg;
         A_CLKON: rd_data[NUM_SYS-1:0] = sys_en;
         default: begin
            for (int i = 0; i < NUM_SYS; i++) begin
               if (rd_addr == A_SYS0 + REG_AW'(i)) begin
                  rd_data[RATIO_W-1:0] = pend[i];
                  rd_data[EN_POS]      = sys_en[i];
               end
            end
         end
      endcase
   end

   AST_GO_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      go_start |=> (chg == '0)); // R8
endmodule

// File: rtl/clkdiv_go_seq.sv
module clkdiv_go_seq #(
   parameter int NUM_SYS = 3,
   parameter int RATIO_W = 5
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            go_start,
   input  logic                            step,
   input  logic [NUM_SYS-1:0]              align_in,
   input  logic [NUM_SYS-1:0][RATIO_W-1:0] act_ratio,
   input  logic [NUM_SYS-1:0]              at_end,
   output logic                            busy,
   output logic                            apply,
   output logic [NUM_SYS-1:0]              align_q
);
   localparam int LW = (NUM_SYS > 1) ? $clog2(NUM_SYS) : 1;

   logic [LW-1:0]      lead;
   logic [RATIO_W-1:0] best;
   logic               found;

   // slowest aligned divider; lowest index wins a tie
   always_comb begin
      lead  = '0;
      best  = '0;
      found = 1'b0;
      for (int i = 0; i < NUM_SYS; i++) begin
         if (align_q[i] && (!found || act_ratio[i] > best)) begin
            found = 1'b1;
            best  = act_ratio[i];
            lead  = LW'(i);
         end
      end
   end

   assign apply = busy && step && (!found || at_end[lead]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         align_q <= '0;
      end else if (go_start) begin
         busy    <= 1'b1;
         align_q <= align_in;
      end else if (apply) begin
         busy    <= 1'b0;
      end
   end

   AST_GO_RAISES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      go_start |=> busy); // R6
   AST_BUSY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      apply |=> !busy); // R7
   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step) |=> busy); // R9
endmodule

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
   import clkdiv_pkg::*;
#(
   parameter int NUM_SYS = 3,
   parameter int RATIO_W = 5
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ref_edge,
   input  logic               mul_edge,
   input  logic               wr_en,
   input  logic [REG_AW-1:0]  wr_addr,
   input  logic [REG_DW-1:0]  wr_data,
   input  logic [REG_AW-1:0]  rd_addr,
   output logic [REG_DW-1:0]  rd_data,
   output logic [NUM_SYS-1:0] sys_pulse,
   output logic               byp_pulse,
   output logic               obs_pulse,
   output logic               go_busy
);
   if (NUM_SYS < 1 || NUM_SYS > 8) begin : g_bad_num
      $error("NUM_SYS must lie in 1..8");
   end
   if (RATIO_W < 3 || RATIO_W > 8) begin : g_bad_width
      $error("RATIO_W must lie in 3..8");
   end

   logic                            go_start, mul_sel, apply, src_step;
   logic                            byp_en, byp_load, obs_en, obs_load;
   logic [NUM_SYS-1:0]              sys_en, apply_mask, align, align_q, at_end;
   logic [NUM_SYS-1:0][RATIO_W-1:0] armed, act_ratio;
   logic                            byp_end, obs_end;
   logic [RATIO_W-1:0]              byp_ratio, obs_ratio;

   assign src_step = mul_sel ? mul_edge : ref_edge;

   clkdiv_regs #(.NUM_SYS(NUM_SYS), .RATIO_W(RATIO_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .busy(go_busy), .go_start(go_start), .mul_sel(mul_sel),
      .sys_en(sys_en), .armed(armed), .apply_mask(apply_mask),
      .align(align), .byp_en(byp_en), .byp_load(byp_load),
      .obs_en(obs_en), .obs_load(obs_load)
   );

   clkdiv_go_seq #(.NUM_SYS(NUM_SYS), .RATIO_W(RATIO_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .go_start(go_start), .step(src_step),
      .align_in(align), .act_ratio(act_ratio), .at_end(at_end),
      .busy(go_busy), .apply(apply), .align_q(align_q)
   );

   for (genvar i = 0; i < NUM_SYS; i++) begin : g_sys
      clkdiv_counter #(
         .RATIO_W(RATIO_W),
         .RST_RATIO(RATIO_W'(sys_reset_ratio(i)))
      ) u_div (
         .clk(clk), .rst_n(rst_n), .step(src_step), .en(sys_en[i]),
         .load(apply && apply_mask[i]), .load_ratio(armed[i]),
         .restart(apply && align_q[i]), .pulse(sys_pulse[i]),
         .at_end(at_end[i]), .ratio_q(act_ratio[i])
      );
   end

   clkdiv_counter #(.RATIO_W(RATIO_W), .RST_RATIO('0)) u_byp (
      .clk(clk), .rst_n(rst_n), .step(ref_edge), .en(byp_en),
      .load(byp_load), .load_ratio(wr_data[RATIO_W-1:0]), .restart(1'b0),
      .pulse(byp_pulse), .at_end(byp_end), .ratio_q(byp_ratio)
   );

   clkdiv_counter #(.RATIO_W(RATIO_W), .RST_RATIO('0)) u_obs (
      .clk(clk), .rst_n(rst_n), .step(ref_edge), .en(obs_en),
      .load(obs_load), .load_ratio(wr_data[RATIO_W-1:0]), .restart(1'b0),
      .pulse(obs_pulse), .at_end(obs_end), .ratio_q(obs_ratio)
   );

   logic unused_status;
   assign unused_status = ^{byp_end, obs_end, byp_ratio, obs_ratio};

   AST_REF_ONLY_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      !ref_edge |=> !byp_pulse && !obs_pulse); // R10
   AST_SRC_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
      !src_step |=> (sys_pulse == '0)); // R2
endmodule

// File: tb/clkdiv_ctrl_test.sv
module clkdiv_ctrl_test;
   import clkdiv_pkg::*;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_edge = 1'b0, mul_edge = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0, rd_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [2:0]  sys_pulse;
   logic        byp_pulse, obs_pulse, go_busy;
   logic [4:0]  all_p;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   typedef struct {
      logic [3:0]  addr;
      logic [15:0] exp;
      string       tag;
   } rd_item_t;
   rd_item_t sb_q[$];

   always #10 clk = ~clk;

   clkdiv_ctrl uut (
      .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .mul_edge(mul_edge),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sys_pulse(sys_pulse),
      .byp_pulse(byp_pulse), .obs_pulse(obs_pulse), .go_busy(go_busy)
   );

   assign all_p = {obs_pulse, byp_pulse, sys_pulse};

   // source strobes: reference every 4th clock, multiplied every 2nd
   always @(negedge clk) begin
      cyc      <= cyc + 1;
      ref_edge <= (cyc % 4 == 0);
      mul_edge <= (cyc % 2 == 0);
   end

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // scoreboard driver: queue an expected register value, wait for the monitor
   task automatic expect_reg(input logic [3:0] a, input logic [15:0] e, input string tag);
      rd_item_t it;
      it.addr = a; it.exp = e; it.tag = tag;
      sb_q.push_back(it);
      wait (sb_q.size() == 0);
   endtask

   // scoreboard monitor
   initial begin
      forever begin
         wait (sb_q.size() > 0);
         @(negedge clk);
         rd_addr = sb_q[0].addr;
         #1;
         checks++;
         if (rd_data !== sb_q[0].exp) begin
            fails++;
            $display("FAIL %s: addr %0d actual 0x%04h expected 0x%04h",
                     sb_q[0].tag, sb_q[0].addr, rd_data, sb_q[0].exp);
         end
         void'(sb_q.pop_front());
      end
   end

   task automatic wr(input logic [3:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic wait_pulse(input int ch);
      int n = 0;
      do begin @(negedge clk); n++; end while (!all_p[ch] && n < 400);
   endtask

   task automatic period(input int ch, output int p);
      int n = 0;
      wait_pulse(ch);
      do begin @(negedge clk); n++; end while (!all_p[ch] && n < 400);
      p = all_p[ch] ? n : -1;
   endtask

   task automatic count_pulses(input int ch, input int span, output int k);
      k = 0;
      for (int j = 0; j < span; j++) begin
         @(negedge clk);
         if (all_p[ch]) k++;
      end
   endtask

   initial begin
      #(20 * 100000);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int p;
      int k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1 reset state
      expect_reg(A_CTRL,  16'h0000, "R1 ctrl");
      expect_reg(A_SYS0,  16'h8000, "R1 sys0");
      expect_reg(A_SYS0 + 4'd1, 16'h8002, "R1 sys1");
      expect_reg(A_SYS0 + 4'd2, 16'h8005, "R1 sys2");
      expect_reg(A_BYP,   16'h8000, "R1 byp");
      expect_reg(A_OBS,   16'h8000, "R1 obs");
      expect_reg(A_ALIGN, 16'h0007, "R1 align");
      expect_reg(A_STAT,  16'h0000, "R1 busy");
      expect_reg(A_CHG,   16'h0000, "R1 chg");
      expect_reg(A_CLKON, 16'h0007, "R1 clkon");

      // R3 default periods on reference (gap 4)
      period(0, p); check("R3 sys0 period", p, 4);
      period(1, p); check("R3 sys1 period", p, 12);
      period(2, p); check("R3 sys2 period", p, 24);
      period(3, p); check("R10 byp period", p, 4);
      period(4, p); check("R10 obs period", p, 4);

      // R2 switch to multiplied source (gap 2)
      wr(A_CTRL, 16'h0001);
      period(1, p); period(1, p); check("R2 sys1 on mul", p, 6);
      period(3, p); check("R10 byp stays on ref", p, 4);

      // R5 staged write
      wr(A_SYS0 + 4'd1, 16'h8003);
      expect_reg(A_SYS0 + 4'd1, 16'h8003, "R5 readback");
      expect_reg(A_CHG, 16'h0002, "R5 chg flag");
      period(1, p); check("R5 period unchanged", p, 6);

      // R6 GO with 0 does nothing
      wr(A_GO, 16'h0000);
      expect_reg(A_STAT, 16'h0000, "R6 go0 busy");
      expect_reg(A_CHG,  16'h0002, "R6 go0 chg kept");

      // R6/R7 real GO, synced after slowest output pulse
      wait_pulse(2);
      wr(A_GO, 16'h0001);
      expect_reg(A_STAT, 16'h0001, "R6 busy set");
      k = 0;
      while (go_busy && k < 200) begin @(negedge clk); k++; end
      check("R7 busy cleared", go_busy, 0);
      wait_pulse(2);
      check("R7 aligned pulses", sys_pulse, 3'b111);
      period(1, p); check("R7 sys1 new period", p, 8);
      period(2, p); check("R7 sys2 period", p, 12);
      expect_reg(A_CHG, 16'h0000, "R8 chg cleared");

      // R8/R9 writes and GO during busy
      wait_pulse(2);
      wr(A_GO, 16'h0001);
      wr(A_SYS0 + 4'd2, 16'h8001);
      wr(A_GO, 16'h0001);
      expect_reg(A_CHG, 16'h0004, "R9 second GO ignored");
      k = 0;
      while (go_busy && k < 200) begin @(negedge clk); k++; end
      period(2, p); check("R8 held write not applied", p, 12);
      expect_reg(A_CHG, 16'h0004, "R8 chg still set");
      expect_reg(A_SYS0 + 4'd2, 16'h8001, "R8 readback");
      wr(A_GO, 16'h0001);
      k = 0;
      while (go_busy && k < 200) begin @(negedge clk); k++; end
      period(2, p); check("R8 applied by next GO", p, 4);

      // R4 enable gating
      wr(A_SYS0, 16'h0000);
      expect_reg(A_CLKON, 16'h0006, "R4 clkon");
      count_pulses(0, 30, k); check("R4 sys0 gated", k, 0);
      wr(A_SYS0, 16'h8000);
      period(0, p); check("R4 sys0 restored", p, 2);

      // R10 bypass and observation dividers
      wr(A_BYP, 16'h8002);
      period(3, p); period(3, p); check("R10 byp ratio", p, 12);
      wr(A_OBS, 16'h0001);
      count_pulses(4, 30, k); check("R10 obs gated", k, 0);

      // R7 empty align mask completes at next source edge
      wr(A_ALIGN, 16'h0000);
      wr(A_SYS0 + 4'd1, 16'h8000);
      wr(A_GO, 16'h0001);
      repeat (4) @(negedge clk);
      check("R7 empty align done", go_busy, 0);
      period(1, p); period(1, p); check("R7 sys1 ratio 1", p, 2);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule